// File: doc/BRIEF.md
# Raster Geometry Calculator

The block turns a set of stored display timing-edge values into the figures a scan-out engine needs: the visible width and height, the horizontal and vertical blanking spans, and the total number of pixel clocks in one frame. Each horizontal figure is a difference between two edge positions. It is then scaled by a power-of-two clock divisor, which comes from a 2-bit code. The vertical edges count half-lines, so each vertical figure is halved.

A single-cycle `start` pulse samples all inputs. The geometry figures are registered on that same edge. The frame total is then formed by a shift-add multiplier that takes one cycle per multiplier bit. A one-cycle `done` pulse marks the point where every output is valid. If any difference is negative, the block raises `err`, forces all five results to zero and reports `done` at once. Results hold until the next accepted start.

The controller has three states. `ST_IDLE` waits, and `start` moves it to `ST_MULT` on the accept transition. If the sampled values are invalid, the error transition goes straight to `ST_DONE`. `ST_MULT` performs one shift-add step per cycle, and after the last step the finish transition goes to `ST_DONE`. `ST_DONE` pulses `done`, and the return transition goes back to `ST_IDLE`.

Top module: `raster_geom_calc`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `done`, `err` and all five result outputs are 0.
- R2: The divisor is 2 raised to (`div_code`+1), so codes 0, 1, 2 and 3 give 2, 4, 8 and 16. `width` is (`h_fporch` − `h_actv`) times the divisor.
- R3: `height` is (`v_fporch` − `v_actv`) shifted right by one, with the remainder dropped.
- R4: `hblank` is (`h_actv` + (`h_syncpos` − `h_fporch`)) times the divisor.
- R5: `vblank` is (`v_actv` + (`v_syncpos` − `v_fporch`)) shifted right by one.
- R6: When `done` is high with `err` low, `frame_px` equals (`width`+`hblank`) × (`height`+`vblank`).
- R7: A start is accepted only when `busy` is low. For valid inputs, `done` is high for exactly one cycle, W+1 clock edges after the accepting edge. `busy` is high from the accepting edge through the `done` cycle, and `done` is never high with `busy` low.
- R8: If `h_fporch`<`h_actv`, `h_syncpos`<`h_fporch`, `v_fporch`<`v_actv` or `v_syncpos`<`v_fporch`, then `err` goes high and all five results are 0 from the accepting edge. In that case `done` is high in the very next cycle.
- R9: A `start` raised while `busy` is high, including during the `done` cycle, has no effect on any output.
- R10: While idle, all results and `err` keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Sample inputs and begin a calculation |
| div_code | input | 2 | Clock-divisor code |
| h_fporch | input | W | Horizontal front-porch edge |
| h_actv | input | W | Horizontal active-line edge |
| h_syncpos | input | W | Horizontal sync position |
| v_fporch | input | W | Vertical front-porch edge (half-lines) |
| v_actv | input | W | Vertical active-line edge (half-lines) |
| v_syncpos | input | W | Vertical sync edge (half-lines) |
| busy | output | 1 | Calculation in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Negative difference seen on the last accepted start |
| width | output | W+4 | Active width in pixels |
| height | output | W-1 | Active height in lines |
| hblank | output | W+5 | Horizontal blanking in pixels |
| vblank | output | W | Vertical blanking in lines |
| frame_px | output | 2W+7 | Pixel clocks per frame |

## Verification
Two events can fall in the same cycle: the completion pulse and a new start request. The bench raises `start` with a different parameter set exactly in the `done` cycle. It also raises one partway through the multiply. The cycle-by-cycle model treats both requests as ignored. It then checks that the earlier results are still held and that no second `done` follows. The error path also makes `done` coincide with the cycle right after the accept.

// File: rtl/raster_geom_pkg.sv
package raster_geom_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MULT = 2'd1,
        ST_DONE = 2'd2
    } geom_state_e;

endpackage

// File: rtl/raster_geom_front.sv
module raster_geom_front #(
    parameter int W = 12
) (
    input  logic [1:0]     div_code,
    input  logic [W-1:0]   h_fporch,
    input  logic [W-1:0]   h_actv,
    input  logic [W-1:0]   h_syncpos,
    input  logic [W-1:0]   v_fporch,
    input  logic [W-1:0]   v_actv,
    input  logic [W-1:0]   v_syncpos,
    output logic [W+3:0]   width,
    output logic [W-2:0]   height,
    output logic [W+4:0]   hblank,
    output logic [W-1:0]   vblank,
    output logic [W+5:0]   htot,
    output logic [W:0]     vtot,
    output logic           neg
);

    logic [W:0]   hdiff, hsd, vdiff, vsd;
    logic [W:0]   hb_sum, vb_sum;
    logic [2:0]   shamt;

    always_comb begin
        // Differences are one bit wider so the top bit flags a borrow.
        hdiff  = {1'b0, h_fporch}  - {1'b0, h_actv};
        hsd    = {1'b0, h_syncpos} - {1'b0, h_fporch};
        vdiff  = {1'b0, v_fporch}  - {1'b0, v_actv};
        vsd    = {1'b0, v_syncpos} - {1'b0, v_fporch};
        neg    = hdiff[W] | hsd[W] | vdiff[W] | vsd[W];

        hb_sum = {1'b0, h_actv} + {1'b0, hsd[W-1:0]};
        vb_sum = {1'b0, v_actv} + {1'b0, vsd[W-1:0]};

        // Power-of-two divisor: multiply becomes a shift by code+1.
        shamt  = {1'b0, div_code} + 3'd1;
        width  = (W+4)'(hdiff[W-1:0]) << shamt;
        hblank = (W+5)'(hb_sum) << shamt;

        // Vertical edges count half-lines.
        height = vdiff[W-1:1];
        vblank = vb_sum[W:1];

        htot   = (W+6)'(width) + (W+6)'(hblank);
        vtot   = (W+1)'(height) + (W+1)'(vblank);
    end

endmodule

// File: rtl/raster_shift_add_mul.sv
module raster_shift_add_mul #(
    parameter int AW = 18,
    parameter int BW = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [AW-1:0]     a,
    input  logic [BW-1:0]     b,
    output logic [AW+BW-1:0]  prod
);

    localparam int PW = AW + BW;

    logic [PW-1:0] mc_q;
    logic [BW-1:0] mp_q;
    logic [PW-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mc_q  <= '0;
            mp_q  <= '0;
            acc_q <= '0;
        end else if (load) begin
            mc_q  <= PW'(a);
            mp_q  <= b;
            acc_q <= '0;
        end else if (step) begin
            if (mp_q[0]) begin
                acc_q <= acc_q + mc_q;
            end
            mc_q <= mc_q << 1;
            mp_q <= mp_q >> 1;
        end
    end

    assign prod = acc_q;

endmodule

// File: rtl/raster_geom_calc.sv
module raster_geom_calc
    import raster_geom_pkg::*;
#(
    parameter int W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        div_code,
    input  logic [W-1:0]      h_fporch,
    input  logic [W-1:0]      h_actv,
    input  logic [W-1:0]      h_syncpos,
    input  logic [W-1:0]      v_fporch,
    input  logic [W-1:0]      v_actv,
    input  logic [W-1:0]      v_syncpos,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [W+3:0]      width,
    output logic [W-2:0]      height,
    output logic [W+4:0]      hblank,
    output logic [W-1:0]      vblank,
    output logic [2*W+6:0]    frame_px
);

    localparam int AW = W + 6;
    localparam int BW = W + 1;
    localparam int CW = $clog2(BW);

    geom_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;

    logic [W+3:0]  f_width;
    logic [W-2:0]  f_height;
    logic [W+4:0]  f_hblank;
    logic [W-1:0]  f_vblank;
    logic [AW-1:0] f_htot;
    logic [BW-1:0] f_vtot;
    logic          f_neg;

    logic          accept, last_step;
    logic          busy_d, done_d;

    raster_geom_front #(.W(W)) front_i (
        .div_code  (div_code),
        .h_fporch  (h_fporch),
        .h_actv    (h_actv),
        .h_syncpos (h_syncpos),
        .v_fporch  (v_fporch),
        .v_actv    (v_actv),
        .v_syncpos (v_syncpos),
        .width     (f_width),
        .height    (f_height),
        .hblank    (f_hblank),
        .vblank    (f_vblank),
        .htot      (f_htot),
        .vtot      (f_vtot),
        .neg       (f_neg)
    );

    raster_shift_add_mul #(.AW(AW), .BW(BW)) mul_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .step  (state_q == ST_MULT),
        .a     (f_neg ? '0 : f_htot),
        .b     (f_neg ? '0 : f_vtot),
        .prod  (frame_px)
    );

    assign accept    = (state_q == ST_IDLE) && start;
    assign last_step = (cnt_q == CW'(BW - 1));

    // Next state and Moore outputs.
    always_comb begin
        state_d = state_q;
        busy_d  = 1'b1;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_d = 1'b0;
                if (start) begin
                    state_d = f_neg ? ST_DONE : ST_MULT;
                end
            end
            ST_MULT: begin
                if (last_step) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                done_d  = 1'b1;
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign busy = busy_d;
    assign done = done_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result and step-count registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            err    <= 1'b0;
            width  <= '0;
            height <= '0;
            hblank <= '0;
            vblank <= '0;
        end else if (accept) begin
            cnt_q  <= '0;
            err    <= f_neg;
            width  <= f_neg ? '0 : f_width;
            height <= f_neg ? '0 : f_height;
            hblank <= f_neg ? '0 : f_hblank;
            vblank <= f_neg ? '0 : f_vblank;
        end else if (state_q == ST_MULT) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/raster_geom_calc_chk.sv
module raster_geom_calc_chk #(
    parameter int W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [W-1:0]      h_fporch,
    input logic [W-1:0]      h_actv,
    input logic [W-1:0]      h_syncpos,
    input logic [W-1:0]      v_fporch,
    input logic [W-1:0]      v_actv,
    input logic [W-1:0]      v_syncpos,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [W+3:0]      width,
    input logic [W-2:0]      height,
    input logic [W+4:0]      hblank,
    input logic [W-1:0]      vblank,
    input logic [2*W+6:0]    frame_px
);

    localparam int PW = 2*W + 7;

    logic [PW-1:0] exp_prod;
    logic          bad_in;

    always_comb begin
        exp_prod = (PW'(width) + PW'(hblank)) * (PW'(height) + PW'(vblank));
        bad_in   = (h_fporch < h_actv) || (h_syncpos < h_fporch) ||
                   (v_fporch < v_actv) || (v_syncpos < v_fporch);
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (width == '0 && height == '0 && hblank == '0 &&
                 vblank == '0 && frame_px == '0));

    assert_err_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && bad_in) |=> (done && err));

    assert_frame_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (frame_px == exp_prod));

    assert_busy_geom_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(width) && $stable(height) && $stable(hblank) &&
                  $stable(vblank) && $stable(err)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(width) && $stable(height) &&
                               $stable(hblank) && $stable(vblank) &&
                               $stable(frame_px) && $stable(err) && !busy));

endmodule

bind raster_geom_calc raster_geom_calc_chk #(.W(W)) chk_i (.*);

// File: tb/raster_geom_calc_tb_top.sv
`timescale 1ns/1ps
module raster_geom_calc_tb_top;

    localparam int W  = 12;
    localparam int VW = W + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [1:0]     div_code = '0;
    logic [W-1:0]   h_fporch = '0, h_actv = '0, h_syncpos = '0;
    logic [W-1:0]   v_fporch = '0, v_actv = '0, v_syncpos = '0;
    logic           busy, done, err;
    logic [W+3:0]   width;
    logic [W-2:0]   height;
    logic [W+4:0]   hblank;
    logic [W-1:0]   vblank;
    logic [2*W+6:0] frame_px;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    raster_geom_calc #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .div_code(div_code),
        .h_fporch(h_fporch), .h_actv(h_actv), .h_syncpos(h_syncpos),
        .v_fporch(v_fporch), .v_actv(v_actv), .v_syncpos(v_syncpos),
        .busy(busy), .done(done), .err(err), .width(width), .height(height),
        .hblank(hblank), .vblank(vblank), .frame_px(frame_px)
    );

    // Behavioural reference model.
    bit     m_busy, m_err;
    int     m_cnt;
    longint m_w, m_h, m_hb, m_vb, m_frame, m_prod;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_err = 0; m_cnt = 0;
            m_w = 0; m_h = 0; m_hb = 0; m_vb = 0; m_frame = 0; m_prod = 0;
        end else if (m_busy) begin
            if (m_cnt == 0) m_busy = 0;
            else begin
                m_cnt--;
                if (m_cnt == 0) m_frame = m_prod;
            end
        end else if (start) begin
            longint div;
            div = longint'(1) << (int'(div_code) + 1);
            m_busy = 1;
            if (h_fporch < h_actv || h_syncpos < h_fporch ||
                v_fporch < v_actv || v_syncpos < v_fporch) begin
                m_err = 1; m_cnt = 0;
                m_w = 0; m_h = 0; m_hb = 0; m_vb = 0; m_frame = 0;
            end else begin
                m_err = 0; m_cnt = VW; m_frame = 0;
                m_w  = (longint'(h_fporch) - longint'(h_actv)) * div;
                m_h  = (longint'(v_fporch) - longint'(v_actv)) / 2;
                m_hb = (longint'(h_actv) + longint'(h_syncpos) - longint'(h_fporch)) * div;
                m_vb = (longint'(v_actv) + longint'(v_syncpos) - longint'(v_fporch)) / 2;
                m_prod = (m_w + m_hb) * (m_h + m_vb);
            end
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        string tg;
        tg = rst_n ? "" : "R1 ";
        chk({tg, "R7 busy"}, longint'(busy), longint'(m_busy));
        chk({tg, "R7 done"}, longint'(done), longint'(m_busy && m_cnt == 0));
        chk({tg, "R8 err"},  longint'(err),  longint'(m_err));
        chk({tg, "R2 width"},  longint'(width),  m_w);
        chk({tg, "R3 height"}, longint'(height), m_h);
        chk({tg, "R4 hblank"}, longint'(hblank), m_hb);
        chk({tg, "R5 vblank"}, longint'(vblank), m_vb);
        if (!m_busy || m_cnt == 0)
            chk({tg, "R6 frame"}, longint'(frame_px), m_frame);
    end

    task automatic drive(input int code, input int hf, input int ha, input int hs,
                         input int vf, input int va, input int vs);
        div_code = 2'(code);
        h_fporch = W'(hf); h_actv = W'(ha); h_syncpos = W'(hs);
        v_fporch = W'(vf); v_actv = W'(va); v_syncpos = W'(vs);
    endtask

    task automatic run(input int code, input int hf, input int ha, input int hs,
                       input int vf, input int va, input int vs);
        @(negedge clk);
        drive(code, hf, ha, hs, vf, va, vs);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", longint'(busy), 0);

        // Main function, each divisor code.
        run(0, 680, 40, 700, 990, 30, 1000);
        chk("R6 frame 1400x500", longint'(frame_px), 700000);
        run(1, 680, 40, 700, 990, 30, 1000);
        chk("R2 width code1", longint'(width), 2560);
        run(2, 300, 100, 340, 601, 20, 611);
        chk("R3 height odd floor", longint'(height), 290);
        run(3, 4095, 0, 4095, 4095, 0, 4095);
        chk("R4 hblank code3 max", longint'(hblank), 0);
        run(3, 200, 200, 250, 100, 100, 101);
        chk("R2 zero width", longint'(width), 0);
        run(1, 1000, 123, 1111, 2000, 77, 2345);

        // Negative differences, one per pair.
        run(0, 10, 20, 30, 100, 10, 200);
        chk("R8 h_fporch<h_actv err", longint'(err), 1);
        run(0, 50, 20, 30, 100, 10, 200);
        chk("R8 h_syncpos<h_fporch err", longint'(err), 1);
        run(0, 50, 20, 60, 5, 10, 200);
        chk("R8 v_fporch<v_actv err", longint'(err), 1);
        run(0, 50, 20, 60, 100, 10, 90);
        chk("R8 v_syncpos<v_fporch frame", longint'(frame_px), 0);

        // Start during multiply and during the done cycle.
        @(negedge clk);
        drive(0, 680, 40, 700, 990, 30, 1000);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        drive(2, 900, 10, 950, 800, 2, 900);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!(m_busy && m_cnt == 0)) @(negedge clk);
        chk("R7 done seen", longint'(done), 1);
        drive(3, 10, 20, 5, 1, 2, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 start ignored busy", longint'(busy), 0);
        chk("R9 width kept", longint'(width), 1280);
        chk("R9 err kept", longint'(err), 0);
        repeat (5) @(negedge clk);
        chk("R10 frame held", longint'(frame_px), 700000);
        chk("R10 vblank held", longint'(vblank), 20);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule